// File: doc/BRIEF.md
# Unified Carry-Save Add-and-Reduce Datapath

This block is the arithmetic core of a divider/multiplier that works over either prime fields or binary extension fields. In one clock cycle it takes a carry-save accumulator, adds or subtracts a third operand, adds the modulus when the partial result is odd, and can halve the outcome. Every adder bit cell either acts as a full adder (integer mode) or drops its carry and returns the XOR of its inputs (binary polynomial mode). The depth is two adder cells plus one multiplexer, whatever the width.

Next to the adders sits a loadable right-shift register that holds the multiplier operand. Its lowest bit is exported so that a sequencer can decide between the add and no-add forms of each iteration. The register file and the sequencer that drive this block sit outside it.

Top module: `ucsa_unified_dp`

## Requirements
- R1: With field_int=1, neg=0, sel_zero=0 and shift_en=0, res_sum+res_cry modulo 2^DATA_W equals acc_sum+acc_cry+opnd+u_lsb*modulus modulo 2^DATA_W.
- R2: With field_int=1 and neg=1, the first stage subtracts: res_sum+res_cry modulo 2^DATA_W equals acc_sum+acc_cry−opnd+u_lsb*modulus modulo 2^DATA_W.
- R3: With field_int=0, res_cry is all zeros and res_sum is the bitwise XOR of acc_sum, acc_cry, opnd and (modulus when u_lsb=1). neg has no effect in this mode.
- R4: u_lsb is bit 0 of the first-stage result: in integer mode, bit 0 of acc_sum+acc_cry±opnd; in binary mode, bit 0 of acc_sum^acc_cry^opnd.
- R5: With sel_zero=1, the modulus term is zero whatever u_lsb is, so the result is the first-stage value alone.
- R6: With shift_en=1, both output vectors are shifted right by one bit with a zero in the top bit. In integer mode, res_sum+res_cry modulo 2^(DATA_W−1) equals the floor of half the unshifted result modulo 2^DATA_W. In binary mode, res_sum is the unshifted XOR value shifted right by one.
- R7: When load_y=1 at a clock edge, the multiplier register takes y_in, and c0 shows y_in[0] after that edge. load_y takes priority over shift_y.
- R8: When shift_y=1 and load_y=0 at a clock edge, the register shifts right by one and fills its top bit with zero. c0 therefore walks through the loaded bits from least significant upward, then reads 0.
- R9: When load_y=0 and shift_y=0, the register keeps its value and c0 holds.
- R10: While rst_n is low, and for two clock edges after it rises, the register is cleared and c0 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the multiplier register |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| field_int | input | 1 | 1 selects integer (prime field) mode, 0 selects carry-free binary mode |
| neg | input | 1 | Subtract opnd in the first stage (integer mode only) |
| sel_zero | input | 1 | Forces the modulus term of the second stage to zero |
| shift_en | input | 1 | Selects the one-bit right-shifted result |
| acc_sum | input | DATA_W | Sum vector of the carry-save accumulator |
| acc_cry | input | DATA_W | Carry vector of the carry-save accumulator |
| opnd | input | DATA_W | Third operand of the first stage |
| modulus | input | DATA_W | Modulus added in the second stage when the partial result is odd |
| y_in | input | DATA_W | Value loaded into the multiplier register |
| load_y | input | 1 | Load the multiplier register |
| shift_y | input | 1 | Shift the multiplier register right by one |
| res_sum | output | DATA_W | Sum vector of the result |
| res_cry | output | DATA_W | Carry vector of the result |
| u_lsb | output | 1 | Parity of the first-stage result; gates the modulus |
| c0 | output | 1 | Lowest bit of the multiplier register |

## Verification
The embedded properties watch, on every cycle, that binary mode never produces a carry, that a shifted result always has empty top bits, and that the multiplier register obeys its load, shift and hold rules and its priority. Whether the resolved carry-save value is arithmetically right only shows against the bench's integer model. The same holds for the handling of negation and modulus gating under mixed operands, the wrap modulo the vector width, and the parity that gates the modulus. The bench therefore sweeps every combination of mode, negation, zero-select and shift with varied operands, and steps the register through a full load-and-drain sequence.

// File: rtl/ucsa_pkg.sv
package ucsa_pkg;

  // Field selection encoding shared by every adder cell.
  typedef enum logic {
    FIELD_BIN = 1'b0,
    FIELD_INT = 1'b1
  } field_e;

  // Number of flops in the reset release synchroniser.
  localparam int unsigned RST_SYNC_STAGES = 2;

endpackage

// File: rtl/ucsa_cell.sv
// One bit of a unified 3:2 compressor. In integer mode it is a full adder;
// in binary mode the carry is suppressed and only the XOR remains.
module ucsa_cell (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  input  logic int_mode_i,
  output logic sum_o,
  output logic cry_o
);

  logic maj;

  always_comb begin
    maj   = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
    sum_o = a_i ^ b_i ^ c_i;
    cry_o = int_mode_i & maj;
  end

endmodule

// File: rtl/ucsa_array.sv
// DATA_W-bit unified carry-save adder. The carry vector is weight aligned:
// bit 0 holds the injected carry-in, bit i+1 the carry of cell i. The carry
// out of the top cell is dropped (arithmetic modulo 2^DATA_W).
// HAS_NEG selects the variant whose third operand can be negated.
module ucsa_array #(
  parameter int unsigned DATA_W  = 16,
  parameter bit          HAS_NEG = 1'b0
) (
  input  logic [DATA_W-1:0] x_i,
  input  logic [DATA_W-1:0] y_i,
  input  logic [DATA_W-1:0] z_i,
  input  logic              int_mode_i,
  input  logic              neg_i,
  output logic [DATA_W-1:0] sum_o,
  output logic [DATA_W-1:0] cry_o
);

  logic [DATA_W-1:0] z_eff;
  logic              cin;
  logic [DATA_W-1:0] cell_cry;

  generate
    if (HAS_NEG) begin : g_neg
      logic neg_eff;
      always_comb begin
        // Subtraction only means something in integer mode.
        neg_eff = neg_i & int_mode_i;
        z_eff   = z_i ^ {DATA_W{neg_eff}};
        cin     = neg_eff;
      end
    end else begin : g_plain
      logic unused_neg;
      always_comb begin
        unused_neg = neg_i;
        z_eff      = z_i;
        cin        = 1'b0;
      end
    end
  endgenerate

  generate
    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_cell
      ucsa_cell u_cell (
        .a_i        (x_i[gi]),
        .b_i        (y_i[gi]),
        .c_i        (z_eff[gi]),
        .int_mode_i (int_mode_i),
        .sum_o      (sum_o[gi]),
        .cry_o      (cell_cry[gi])
      );
    end
  endgenerate

  logic unused_top_cry;

  always_comb begin
    cry_o          = {cell_cry[DATA_W-2:0], cin};
    unused_top_cry = cell_cry[DATA_W-1];
  end

endmodule

// File: rtl/ucsa_rshift.sv
// Output selector: either the vectors as they are or each shifted right
// by one bit with zero fill (pure wiring plus one 2:1 mux per bit).
module ucsa_rshift #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              sel_i,
  input  logic [DATA_W-1:0] sum_i,
  input  logic [DATA_W-1:0] cry_i,
  output logic [DATA_W-1:0] sum_o,
  output logic [DATA_W-1:0] cry_o
);

  always_comb begin
    if (sel_i) begin
      sum_o = {1'b0, sum_i[DATA_W-1:1]};
      cry_o = {1'b0, cry_i[DATA_W-1:1]};
    end else begin
      sum_o = sum_i;
      cry_o = cry_i;
    end
  end

endmodule

// File: rtl/ucsa_yreg.sv
// Loadable right-shift register holding the multiplier operand.
module ucsa_yreg #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic [DATA_W-1:0] d_i,
  output logic              lsb_o
);
  import ucsa_pkg::*;

  // Reset: asserted asynchronously, released through a flop chain.
  logic [RST_SYNC_STAGES-1:0] rst_pipe;
  logic                       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[RST_SYNC_STAGES-2:0], 1'b1};
  end

  always_comb rst_int_n = rst_pipe[RST_SYNC_STAGES-1];

  logic [DATA_W-1:0] q;
  logic [DATA_W-1:0] q_nxt;
  logic              q_en;

  always_comb begin
    q_en = load_i | shift_i;
    if (load_i) q_nxt = d_i;
    else        q_nxt = {1'b0, q[DATA_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  q <= '0;
    else if (q_en)   q <= q_nxt;
  end

  always_comb lsb_o = q[0];

  // R7: a load wins and lands on the next edge
  assert_load_wins_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    load_i |=> (q == $past(d_i)));

  // R8: shift without load moves every bit down, zero enters at the top
  assert_shift_fill_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (shift_i && !load_i) |=> (q[DATA_W-1] == 1'b0) && (q[DATA_W-2:0] == $past(q[DATA_W-1:1])));

  // R9: idle cycles keep the contents
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!shift_i && !load_i) |=> $stable(q));

endmodule

// File: rtl/ucsa_unified_dp.sv
// Two-stage unified carry-save datapath:
//   stage 1: acc_sum + acc_cry (+/-) opnd
//   stage 2: stage1 + (u_lsb & ~sel_zero) * modulus
//   output : optional one-bit right shift
module ucsa_unified_dp #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              field_int,
  input  logic              neg,
  input  logic              sel_zero,
  input  logic              shift_en,
  input  logic [DATA_W-1:0] acc_sum,
  input  logic [DATA_W-1:0] acc_cry,
  input  logic [DATA_W-1:0] opnd,
  input  logic [DATA_W-1:0] modulus,
  input  logic [DATA_W-1:0] y_in,
  input  logic              load_y,
  input  logic              shift_y,
  output logic [DATA_W-1:0] res_sum,
  output logic [DATA_W-1:0] res_cry,
  output logic              u_lsb,
  output logic              c0
);
  import ucsa_pkg::*;

  field_e            fmode;
  logic              int_mode;
  logic [DATA_W-1:0] s1_sum, s1_cry;
  logic [DATA_W-1:0] s2_sum, s2_cry;
  logic [DATA_W-1:0] mod_term;
  logic              par;

  always_comb begin
    fmode    = field_e'(field_int);
    int_mode = (fmode == FIELD_INT);
  end

  ucsa_array #(.DATA_W(DATA_W), .HAS_NEG(1'b1)) u_stage1 (
    .x_i        (acc_sum),
    .y_i        (acc_cry),
    .z_i        (opnd),
    .int_mode_i (int_mode),
    .neg_i      (neg),
    .sum_o      (s1_sum),
    .cry_o      (s1_cry)
  );

  // Parity of the stage-1 value; carry bit 0 is the injected carry-in.
  always_comb begin
    if (int_mode) par = s1_sum[0] ^ s1_cry[0];
    else          par = s1_sum[0];
    mod_term = modulus & {DATA_W{par & ~sel_zero}};
    u_lsb    = par;
  end

  ucsa_array #(.DATA_W(DATA_W), .HAS_NEG(1'b0)) u_stage2 (
    .x_i        (s1_sum),
    .y_i        (s1_cry),
    .z_i        (mod_term),
    .int_mode_i (int_mode),
    .neg_i      (1'b0),
    .sum_o      (s2_sum),
    .cry_o      (s2_cry)
  );

  ucsa_rshift #(.DATA_W(DATA_W)) u_shift (
    .sel_i (shift_en),
    .sum_i (s2_sum),
    .cry_i (s2_cry),
    .sum_o (res_sum),
    .cry_o (res_cry)
  );

  ucsa_yreg #(.DATA_W(DATA_W)) u_yreg (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load_y),
    .shift_i (shift_y),
    .d_i     (y_in),
    .lsb_o   (c0)
  );

  // R3: binary mode never produces a carry vector
  assert_bin_no_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !field_int |-> (res_cry == '0));

  // R6: a shifted result leaves both top bits empty
  assert_shift_top_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |-> (!res_sum[DATA_W-1] && !res_cry[DATA_W-1]));

endmodule

// File: tb/ucsa_unified_dp_tb.sv
`timescale 1ns/1ps
module ucsa_unified_dp_tb_top;

  localparam int unsigned DW = 16;
  localparam longint unsigned MASK  = (64'd1 << DW) - 1;
  localparam longint unsigned MASKH = (64'd1 << (DW - 1)) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          field_int = 1'b1, neg = 1'b0, sel_zero = 1'b0, shift_en = 1'b0;
  logic [DW-1:0] acc_sum = '0, acc_cry = '0, opnd = '0, modulus = '0, y_in = '0;
  logic          load_y = 1'b0, shift_y = 1'b0;
  logic [DW-1:0] res_sum, res_cry;
  logic          u_lsb, c0;

  int errors = 0;
  int checks = 0;
  bit running = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ucsa_unified_dp #(.DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .field_int(field_int), .neg(neg),
    .sel_zero(sel_zero), .shift_en(shift_en), .acc_sum(acc_sum),
    .acc_cry(acc_cry), .opnd(opnd), .modulus(modulus), .y_in(y_in),
    .load_y(load_y), .shift_y(shift_y), .res_sum(res_sum),
    .res_cry(res_cry), .u_lsb(u_lsb), .c0(c0)
  );

  task automatic chk(input bit ok, input string tag, input longint unsigned got,
                     input longint unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  // Behavioural model of the multiplier register (after reset release).
  logic [DW-1:0] y_model;
  string         y_tag;
  int            rel_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_model <= '0;
      y_tag   <= "R10";
      rel_cnt <= 0;
    end else if (rel_cnt < 2) begin
      rel_cnt <= rel_cnt + 1;
      y_tag   <= "R10";
    end else if (load_y) begin
      y_model <= y_in;
      y_tag   <= "R7";
    end else if (shift_y) begin
      y_model <= y_model >> 1;
      y_tag   <= "R8";
    end else begin
      y_tag   <= "R9";
    end
  end

  // Per-cycle comparison against an integer / XOR reference.
  always @(negedge clk) begin
    if (running) begin
      longint unsigned bn, t1, t2, x1, x2, m, got, exp;
      bit u0;
      string tag;
      if (field_int) begin
        bn  = neg ? ((~{48'd0, opnd}) + 64'd1) & MASK : {48'd0, opnd};
        t1  = ({48'd0, acc_sum} + {48'd0, acc_cry} + bn) & MASK;
        u0  = t1[0];
        m   = (u0 && !sel_zero) ? {48'd0, modulus} : 64'd0;
        t2  = (t1 + m) & MASK;
        got = ({48'd0, res_sum} + {48'd0, res_cry}) & MASK;
        if (shift_en) begin
          tag = "R6";
          exp = t2 >> 1;
          got = got & MASKH;
        end else begin
          tag = sel_zero ? "R5" : (neg ? "R2" : "R1");
          exp = t2;
        end
        chk(got == exp, tag, got, exp);
      end else begin
        x1 = {48'd0, acc_sum ^ acc_cry ^ opnd};
        u0 = x1[0];
        m  = (u0 && !sel_zero) ? {48'd0, modulus} : 64'd0;
        x2 = x1 ^ m;
        exp = shift_en ? (x2 >> 1) : x2;
        tag = shift_en ? "R6" : (sel_zero ? "R5" : "R3");
        chk({48'd0, res_sum} == exp, tag, {48'd0, res_sum}, exp);
        chk(res_cry == '0, "R3", {48'd0, res_cry}, 64'd0);
      end
      chk(u_lsb == u0, "R4", {63'd0, u_lsb}, {63'd0, u0});
      chk(c0 == y_model[0], y_tag, {63'd0, c0}, {63'd0, y_model[0]});
    end
  end

  task automatic drive(input bit f, input bit n, input bit z, input bit s);
    @(posedge clk); #1;
    field_int = f; neg = n; sel_zero = z; shift_en = s;
    acc_sum = DW'($urandom); acc_cry = DW'($urandom);
    opnd = DW'($urandom); modulus = DW'($urandom) | DW'(1);
    load_y = 1'b0; shift_y = 1'b0;
  endtask

  initial begin
    // R10: register cleared during reset and the synchroniser window
    repeat (3) @(posedge clk);
    #1 load_y = 1'b1; y_in = 16'hFFFF;
    @(negedge clk);
    chk(c0 == 1'b0, "R10", {63'd0, c0}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(c0 == 1'b0, "R10", {63'd0, c0}, 64'd0);
    load_y = 1'b0;
    repeat (3) @(posedge clk);
    #1 running = 1'b1;

    // Every mode combination with varied operands
    for (int i = 0; i < 320; i++) begin
      drive(i[0], i[1], i[2], i[3]);
    end

    // Corner operands: all ones, zero, wrap of subtraction
    drive(1'b1, 1'b1, 1'b0, 1'b0);
    acc_sum = '0; acc_cry = '0; opnd = 16'h0001; modulus = 16'hFFF1;
    drive(1'b1, 1'b0, 1'b0, 1'b1);
    acc_sum = 16'hFFFF; acc_cry = 16'hFFFF; opnd = 16'hFFFF; modulus = 16'h8001;
    drive(1'b0, 1'b1, 1'b0, 1'b0);
    acc_sum = 16'h00F0; acc_cry = 16'h0F01; opnd = 16'h1234; modulus = 16'h8003;

    // R7/R8/R9: load, drain, hold, load-over-shift
    @(posedge clk); #1 y_in = 16'hA5C3; load_y = 1'b1; shift_y = 1'b0;
    for (int k = 0; k < DW + 2; k++) begin
      @(posedge clk); #1 load_y = 1'b0; shift_y = 1'b1;
      acc_sum = DW'($urandom);
    end
    @(posedge clk); #1 y_in = 16'h0001; load_y = 1'b1; shift_y = 1'b1;
    @(posedge clk); #1 load_y = 1'b0; shift_y = 1'b0;
    repeat (4) @(posedge clk);
    #1 y_in = 16'h0006; load_y = 1'b1;
    @(posedge clk); #1 load_y = 1'b0; shift_y = 1'b1;
    repeat (3) @(posedge clk);
    #1 shift_y = 1'b0;

    // Mixed random control including the register
    for (int i = 0; i < 200; i++) begin
      @(posedge clk); #1;
      field_int = 1'($urandom); neg = 1'($urandom); sel_zero = 1'($urandom);
      shift_en = 1'($urandom); acc_sum = DW'($urandom); acc_cry = DW'($urandom);
      opnd = DW'($urandom); modulus = DW'($urandom);
      y_in = DW'($urandom); load_y = 1'($urandom); shift_y = 1'($urandom);
    end
    @(posedge clk);
    @(negedge clk);
    running = 1'b0;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule